// File: doc/BRIEF.md
# Output Driver Strength Step Adjuster

This block follows the adjust phase of an output-driver impedance calibration. It watches extended-mode-register writes whose three-bit calibration field selects exit, drive-high, drive-low, adjust or default. When adjust is entered, it waits for the write latency. It then collects a four-beat burst code from one data lane and moves two independent strength counters: one for the pull-up leg and one for the pull-down leg.

The host issues the adjust write, sends the code as a burst of four beats, and then issues a calibration-exit write. Every calibration-mode write must be followed by an exit. Any other command during calibration is refused and recorded in a sticky error flag. Codes outside the legal set leave both counters untouched.

Top module: `ocd_step_adjust`

## Requirements
- R1: After reset, both step counters hold DEFAULT_STEP (8), and `adj_busy`, `cal_mode` and `ocd_err` are low.
- R2: A mode write (`cmd_valid` and `cmd_emrs1` high) with `cmd_ocd` = 3'b100 raises `cal_mode` and `adj_busy` from the next cycle. A mode write with `cmd_ocd` = 3'b000 drops both from the next cycle.
- R3: A mode write with `cmd_ocd` = 3'b111, accepted outside calibration, loads both counters with DEFAULT_STEP and raises `cal_mode`.
- R4: Beats (`dq_strobe` high) are taken only from the clock edge that comes WL edges after the edge that accepted the adjust write. Earlier strobes are ignored.
- R5: The code is read as beats DT0..DT3 in arrival order. DT3=1 raises pull-up, DT2=1 lowers pull-up, DT1=1 raises pull-down, and DT0=1 lowers pull-down. Combinations such as 0101, 0110, 1001 and 1010 move both counters.
- R6: A code with DT3 and DT2 both set, or DT1 and DT0 both set (for example 0011, 1100, 1111), leaves both counters unchanged.
- R7: Each counter saturates. A raise at 2^STEP_W-1 (15) and a lower at 0 have no effect.
- R8: The counters change once, on the edge after DT3 is taken, and `adj_busy` falls on that edge. Further beats are ignored until a new adjust write.
- R9: A mode write with `cmd_ocd` of 3'b011, 3'b101 or 3'b110 sets `ocd_err`, which stays set until reset. The mode does not change.
- R10: While `cal_mode` is high, any command other than an exit write sets `ocd_err` and is not carried out.
- R11: An exit write on the same edge as DT3 still lets the counter update happen on the following edge.
- R12: A mode write with `cmd_ocd` = 3'b001 or 3'b010 raises `cal_mode` but not `adj_busy`, and strobed beats leave the counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_emrs1 | input | 1 | Command is an extended-mode-register write (else another command) |
| cmd_ocd | input | 3 | Calibration field of the mode write |
| dq_strobe | input | 1 | Beat qualifier for `dq_bit` |
| dq_bit | input | 1 | Serial code bit from one data lane |
| pu_step | output | STEP_W | Pull-up strength step |
| pd_step | output | STEP_W | Pull-down strength step |
| adj_busy | output | 1 | Adjust entered, counter update still pending |
| cal_mode | output | 1 | Calibration mode active, exit required |
| ocd_err | output | 1 | Sticky protocol error |

## Verification
Two events can fall on the same edge: the capture of the last code beat and an exit write that ends calibration. The bench provokes this by driving the exit command together with DT3. It checks that the counters still take the coded step one edge later and that `cal_mode` is low afterwards. A second overlap is a default-load write sent while adjust is pending. Here the bench expects the error flag, an unchanged counter, and `adj_busy` still high.

// File: rtl/ocd_step_adjust.sv
module ocd_step_adjust #(
  parameter int STEP_W       = 4,
  parameter int DEFAULT_STEP = 8,
  parameter int WL           = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_emrs1,
  input  logic [2:0]        cmd_ocd,
  input  logic              dq_strobe,
  input  logic              dq_bit,
  output logic [STEP_W-1:0] pu_step,
  output logic [STEP_W-1:0] pd_step,
  output logic              adj_busy,
  output logic              cal_mode,
  output logic              ocd_err
);
  localparam int WAIT_W = (WL > 1) ? $clog2(WL) : 1;
  localparam logic [STEP_W-1:0] STEP_MAX  = {STEP_W{1'b1}};
  localparam logic [STEP_W-1:0] STEP_INIT = STEP_W'(DEFAULT_STEP);
  localparam logic [WAIT_W-1:0] WAIT_INIT = WAIT_W'(WL - 1);

  logic              cal_q, adj_q, apply_q, err_q;
  logic [WAIT_W-1:0] wait_q;
  logic [1:0]        beat_n;
  logic [3:0]        code_q;
  logic [STEP_W-1:0] pu_q, pd_q, pu_nx, pd_nx;

  wire mode_wr  = cmd_valid & cmd_emrs1;
  wire is_exit  = mode_wr & (cmd_ocd == 3'b000);
  wire is_rsvd  = mode_wr & ((cmd_ocd == 3'b011) | (cmd_ocd == 3'b101) | (cmd_ocd == 3'b110));
  wire refused  = cmd_valid & cal_q & ~is_exit;
  wire take     = mode_wr & ~cal_q & ~is_rsvd;
  wire go_adj   = take & (cmd_ocd == 3'b100);
  wire go_drv   = take & ((cmd_ocd == 3'b001) | (cmd_ocd == 3'b010));
  wire go_dflt  = take & (cmd_ocd == 3'b111);
  wire beat_ok  = dq_strobe & adj_q & (wait_q == '0) & ~apply_q;
  wire last_bt  = beat_ok & (beat_n == 2'd3);

  wire code_ok  = ~(code_q[3] & code_q[2]) & ~(code_q[1] & code_q[0]);

  always_comb begin
    pu_nx = pu_q;
    pd_nx = pd_q;
    if (code_ok) begin
      if (code_q[3] && pu_q != STEP_MAX)  pu_nx = pu_q + 1'b1;
      else if (code_q[2] && pu_q != '0)   pu_nx = pu_q - 1'b1;
      if (code_q[1] && pd_q != STEP_MAX)  pd_nx = pd_q + 1'b1;
      else if (code_q[0] && pd_q != '0)   pd_nx = pd_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q   <= 1'b0;
      adj_q   <= 1'b0;
      apply_q <= 1'b0;
      err_q   <= 1'b0;
      wait_q  <= '0;
      beat_n  <= '0;
      code_q  <= '0;
      pu_q    <= STEP_INIT;
      pd_q    <= STEP_INIT;
    end else begin
      if (apply_q) adj_q <= 1'b0;
      if (is_exit) begin
        cal_q <= 1'b0;
        adj_q <= 1'b0;
      end else if (go_adj) begin
        cal_q  <= 1'b1;
        adj_q  <= 1'b1;
        beat_n <= '0;
      end else if (go_drv || go_dflt) begin
        cal_q <= 1'b1;
      end

      if (refused || is_rsvd) err_q <= 1'b1;

      if (go_adj)              wait_q <= WAIT_INIT;
      else if (wait_q != '0)   wait_q <= wait_q - 1'b1;

      if (beat_ok) begin
        code_q[beat_n] <= dq_bit;
        beat_n         <= beat_n + 1'b1;
      end
      apply_q <= last_bt;

      if (go_dflt) begin
        pu_q <= STEP_INIT;
        pd_q <= STEP_INIT;
      end else if (apply_q) begin
        pu_q <= pu_nx;
        pd_q <= pd_nx;
      end
    end
  end

  assign pu_step  = pu_q;
  assign pd_step  = pd_q;
  assign adj_busy = adj_q;
  assign cal_mode = cal_q;
  assign ocd_err  = err_q;
endmodule

// File: rtl/ocd_step_adjust_chk.sv
module ocd_step_adjust_chk #(
  parameter int STEP_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_emrs1,
  input logic [2:0]        cmd_ocd,
  input logic [STEP_W-1:0] pu_step,
  input logic [STEP_W-1:0] pd_step,
  input logic              adj_busy,
  input logic              cal_mode,
  input logic              ocd_err,
  input logic              apply_q
);
  localparam logic [STEP_W-1:0] TOP = {STEP_W{1'b1}};
  wire dflt = cmd_valid & cmd_emrs1 & (cmd_ocd == 3'b111) & ~cal_mode;
  wire rsvd = cmd_valid & cmd_emrs1 & ((cmd_ocd == 3'b011) | (cmd_ocd == 3'b101) | (cmd_ocd == 3'b110));
  wire exitw = cmd_valid & cmd_emrs1 & (cmd_ocd == 3'b000);

  AST_BUSY_NEEDS_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    adj_busy |-> cal_mode); // R2
  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    exitw |=> (!cal_mode && !adj_busy)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ocd_err) |-> ocd_err); // R9
  AST_RSVD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd |=> ocd_err); // R9
  AST_REFUSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cal_mode && !exitw) |=> ocd_err); // R10
  AST_PU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(apply_q) && !$past(dflt)) |-> $stable(pu_step)); // R8
  AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(apply_q) && !$past(dflt)) |-> $stable(pd_step)); // R8
  AST_PU_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(apply_q) && !$past(dflt) && $past(pu_step) == TOP) |-> (pu_step != '0)); // R7
  AST_PD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(apply_q) && !$past(dflt) && $past(pd_step) == '0) |-> (pd_step != TOP)); // R7
endmodule

bind ocd_step_adjust ocd_step_adjust_chk #(.STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_emrs1(cmd_emrs1),
  .cmd_ocd(cmd_ocd), .pu_step(pu_step), .pd_step(pd_step), .adj_busy(adj_busy),
  .cal_mode(cal_mode), .ocd_err(ocd_err), .apply_q(apply_q)
);

// File: tb/ocd_step_adjust_bench.sv
module ocd_step_adjust_bench;
  localparam int WL = 3;
  localparam int NV = 12;
  // {code DT0..DT3, expected pull-up, expected pull-down}
  localparam logic [11:0] VEC [NV] = '{
    {4'b0001, 4'd9,  4'd8},  {4'b0100, 4'd9,  4'd9},
    {4'b0101, 4'd10, 4'd10}, {4'b0110, 4'd9,  4'd11},
    {4'b1001, 4'd10, 4'd10}, {4'b1010, 4'd9,  4'd9},
    {4'b0010, 4'd8,  4'd9},  {4'b1000, 4'd8,  4'd8},
    {4'b0011, 4'd8,  4'd8},  {4'b1100, 4'd8,  4'd8},
    {4'b1111, 4'd8,  4'd8},  {4'b0000, 4'd8,  4'd8}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_emrs1 = 1'b0, dq_strobe = 1'b0, dq_bit = 1'b0;
  logic [2:0] cmd_ocd = 3'b000;
  logic [3:0] pu_step, pd_step;
  logic adj_busy, cal_mode, ocd_err;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ocd_step_adjust #(.STEP_W(4), .DEFAULT_STEP(8), .WL(WL)) u_ocd_step_adjust (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_emrs1(cmd_emrs1),
    .cmd_ocd(cmd_ocd), .dq_strobe(dq_strobe), .dq_bit(dq_bit),
    .pu_step(pu_step), .pd_step(pd_step), .adj_busy(adj_busy),
    .cal_mode(cal_mode), .ocd_err(ocd_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_cmd(input logic emrs, input logic [2:0] f);
    cmd_valid = 1'b1; cmd_emrs1 = emrs; cmd_ocd = f;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_emrs1 = 1'b0; cmd_ocd = 3'b000;
  endtask

  task automatic beats(input logic [3:0] code, input bit exit_last);
    for (int i = 0; i < 4; i++) begin
      dq_strobe = 1'b1; dq_bit = code[3-i];
      if (exit_last && i == 3) begin
        cmd_valid = 1'b1; cmd_emrs1 = 1'b1; cmd_ocd = 3'b000;
      end
      @(negedge clk);
    end
    dq_strobe = 1'b0; dq_bit = 1'b0;
    cmd_valid = 1'b0; cmd_emrs1 = 1'b0;
  endtask

  task automatic burst(input logic [3:0] code, input bit exit_last, input bit early);
    do_cmd(1'b1, 3'b100);
    if (early) begin dq_strobe = 1'b1; dq_bit = 1'b1; end
    repeat (WL-1) @(negedge clk);
    beats(code, exit_last);
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    check("R1 pu", pu_step, 8);  check("R1 pd", pd_step, 8);
    check("R1 busy", adj_busy, 0); check("R1 cal", cal_mode, 0);
    check("R1 err", ocd_err, 0);

    do_cmd(1'b1, 3'b100);
    check("R2 busy after adjust", adj_busy, 1); check("R2 cal after adjust", cal_mode, 1);
    do_cmd(1'b1, 3'b000);
    check("R2 busy after exit", adj_busy, 0); check("R2 cal after exit", cal_mode, 0);

    for (int v = 0; v < NV; v++) begin
      burst(VEC[v][11:8], 1'b0, 1'b0);
      check("R8 busy low after update", adj_busy, 0);
      do_cmd(1'b1, 3'b000);
      check(v < 8 ? "R5 pu" : "R6 pu", pu_step, int'(VEC[v][7:4]));
      check(v < 8 ? "R5 pd" : "R6 pd", pd_step, int'(VEC[v][3:0]));
    end

    burst(4'b0101, 1'b0, 1'b0); do_cmd(1'b1, 3'b000);
    do_cmd(1'b1, 3'b111);
    check("R3 pu default", pu_step, 8); check("R3 pd default", pd_step, 8);
    check("R3 cal", cal_mode, 1);
    do_cmd(1'b1, 3'b000);

    for (int k = 0; k < 9; k++) begin burst(4'b0101, 1'b0, 1'b0); do_cmd(1'b1, 3'b000); end
    check("R7 pu top", pu_step, 15); check("R7 pd top", pd_step, 15);
    for (int k = 0; k < 17; k++) begin burst(4'b1010, 1'b0, 1'b0); do_cmd(1'b1, 3'b000); end
    check("R7 pu bottom", pu_step, 0); check("R7 pd bottom", pd_step, 0);

    burst(4'b0001, 1'b0, 1'b0);
    beats(4'b0001, 1'b0); @(negedge clk);
    do_cmd(1'b1, 3'b000);
    check("R8 single update pu", pu_step, 1); check("R8 pd", pd_step, 0);

    burst(4'b0000, 1'b0, 1'b1);
    do_cmd(1'b1, 3'b000);
    check("R4 early beats ignored pu", pu_step, 1); check("R4 pd", pd_step, 0);

    do_cmd(1'b1, 3'b001);
    check("R12 cal", cal_mode, 1); check("R12 busy", adj_busy, 0);
    beats(4'b0101, 1'b0); @(negedge clk);
    do_cmd(1'b1, 3'b000);
    check("R12 pu unchanged", pu_step, 1); check("R12 pd unchanged", pd_step, 0);

    burst(4'b0101, 1'b1, 1'b0);
    check("R11 pu updated", pu_step, 2); check("R11 pd updated", pd_step, 1);
    check("R11 cal off", cal_mode, 0);
    check("R11 no error", ocd_err, 0);

    do_cmd(1'b1, 3'b100);
    do_cmd(1'b1, 3'b111);
    check("R10 err on default in adjust", ocd_err, 1);
    check("R10 busy kept", adj_busy, 1);
    check("R10 pu not loaded", pu_step, 2);
    do_cmd(1'b1, 3'b000);

    do_reset();
    do_cmd(1'b1, 3'b100);
    do_cmd(1'b0, 3'b000);
    check("R10 err on other command", ocd_err, 1);
    check("R10 cal kept", cal_mode, 1);

    do_reset();
    do_cmd(1'b1, 3'b101);
    check("R9 err on reserved field", ocd_err, 1);
    check("R9 cal unchanged", cal_mode, 0);
    repeat (3) @(negedge clk);
    check("R9 err sticky", ocd_err, 1);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule